// File: doc/BRIEF.md
# Transport Stream Clock Reference Extractor

This block watches a transport stream delivered one byte per accepted cycle, with a strobe that marks the first byte of each 188-byte packet. For every packet it checks the sync byte, confirms from the header that an adaptation field is present and long enough, and tests the flag that announces a program clock reference. When that flag is set, it gathers the six reference bytes that follow the flags byte. It then issues the reference as one 27 MHz count.

The reference in the stream has two parts. The first is a 33-bit base that ticks at 90 kHz. Six reserved bits follow it, and then a 9-bit extension that ticks at 27 MHz. The block folds the two into a 42-bit 27 MHz value, equal to base × 300 + extension. It raises a one-cycle strobe with that value and also returns the raw base and extension. A downstream clock recovery loop can use whichever form suits it. Between strobes the outputs keep the last result.

Top module: `ts_pcr_extractor`

## Requirements
- R1: While rst_ni is low and after release, pcr_valid_o is 0 and pcr_o, pcr_base_o and pcr_ext_o are all 0 until the first result.
- R2: A packet whose first byte (the byte accepted with sop_i high) is not 0x47 produces no strobe.
- R3: Byte 3 of the packet carries the adaptation-present bit at bit 5. When that bit is 0, the packet produces no strobe.
- R4: Byte 4 is the adaptation length. A value below 7, zero included, produces no strobe.
- R5: Byte 5 is the adaptation flags byte, and the reference flag is its bit 4. When that bit is 0, the packet produces no strobe.
- R6: The base is taken from bytes 6 to 9 (MSB first) followed by bit 7 of byte 10. The extension is bit 0 of byte 10 followed by byte 11. Bits 6..1 of byte 10 are ignored.
- R7: pcr_o equals pcr_base_o × 300 + pcr_ext_o, 42 bits wide, and this holds at the largest base and extension.
- R8: pcr_valid_o is high for exactly one cycle for each qualifying packet. It is visible in the second cycle after the cycle in which byte 11 was presented.
- R9: Cycles with byte_valid_i low do not advance the byte position. A packet with idle gaps gives the same result as one without them.
- R10: sop_i with byte_valid_i restarts parsing at any point. A packet cut short before byte 11 produces no strobe, and a new packet can start in the cycle right after byte 11 of the previous one.
- R11: pcr_o, pcr_base_o and pcr_ext_o change only in a cycle where pcr_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | byte_i and sop_i are taken in this cycle |
| sop_i | input | 1 | Marks byte_i as the first byte of a packet |
| byte_i | input | 8 | Stream byte |
| pcr_valid_o | output | 1 | One-cycle strobe for a new reference |
| pcr_o | output | 42 | Combined 27 MHz reference |
| pcr_base_o | output | 33 | Raw 90 kHz base |
| pcr_ext_o | output | 9 | Raw 27 MHz extension |

## Verification
Two things can fall in the same cycle: the result of one packet leaving the output stage, and the header of the next packet entering the parser. The bench provokes this by starting a packet with sop_i in the cycle directly after byte 11 of a short qualifying packet. It then requires both strobes, each in the expected cycle and carrying its own value. A second case sends sop_i partway through the reference bytes. There the abandoned capture must produce nothing, and the packet that follows must still yield exactly one correct strobe.

// File: rtl/ts_pcr_pkg.sv
package ts_pcr_pkg;
  localparam int BASE_W  = 33;
  localparam int EXT_W   = 9;
  localparam int PCR_W   = 42;
  localparam int HI_BYTES = 4;            // whole base bytes before the split byte
  localparam int HI_W    = HI_BYTES * 8;
  localparam int SCALE   = 300;

  typedef logic [BASE_W-1:0] base_t;
  typedef logic [EXT_W-1:0]  ext_t;
  typedef logic [PCR_W-1:0]  pcr_t;
endpackage

// File: rtl/ts_pkt_parser.sv
module ts_pkt_parser
  import ts_pcr_pkg::*;
#(
  parameter int          PKT_LEN    = 188,
  parameter logic [7:0]  SYNC_BYTE  = 8'h47,
  parameter int          AF_BIT     = 5,
  parameter int          FLAG_BIT   = 4,
  parameter int          MIN_AF_LEN = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sop_i,
  input  logic [7:0] data_i,
  output logic       shift_o,  // bytes holding the upper base bits
  output logic       split_o,  // byte with base LSB and extension MSB
  output logic       done_o    // last extension byte
);
  localparam int IDX_W = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] I_HDR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_LEN  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_FLG  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_F0   = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_SPL  = IDX_W'(6 + HI_BYTES);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(7 + HI_BYTES);
  localparam logic [7:0]       MIN_L  = 8'(MIN_AF_LEN);

  logic             live_q;
  logic             short_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] nxt_idx;
  logic             step;

  assign nxt_idx = idx_q + 1'b1;
  assign step    = valid_i && !sop_i && live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      short_q <= 1'b0;
      idx_q   <= '0;
    end else if (valid_i) begin
      if (sop_i) begin
        live_q  <= (data_i == SYNC_BYTE);
        short_q <= 1'b0;
        idx_q   <= '0;
      end else if (live_q) begin
        idx_q <= nxt_idx;
        unique case (nxt_idx)
          I_HDR:  if (!data_i[AF_BIT]) live_q <= 1'b0;
          I_LEN:  short_q <= (data_i < MIN_L);
          I_FLG:  if (short_q || !data_i[FLAG_BIT]) live_q <= 1'b0;
          I_LAST: live_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign shift_o = step && (nxt_idx >= I_F0) && (nxt_idx < I_SPL);
  assign split_o = step && (nxt_idx == I_SPL);
  assign done_o  = step && (nxt_idx == I_LAST);

  AST_BAD_SYNC_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i && data_i != SYNC_BYTE) |=> !live_q); // R2
  AST_IDX_IN_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> idx_q < I_LAST); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_SOP_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i) |=> !split_o && !done_o); // R10
endmodule

// File: rtl/ts_pcr_capture.sv
module ts_pcr_capture
  import ts_pcr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       shift_i,
  input  logic       split_i,
  input  logic       done_i,
  output base_t      base_o,
  output ext_t       ext_o,
  output logic       vld_o
);
  logic [HI_W-1:0] hi_q;
  logic            b0_q;
  logic            e8_q;
  base_t           base_q;
  ext_t            ext_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      b0_q   <= 1'b0;
      e8_q   <= 1'b0;
      base_q <= '0;
      ext_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= done_i;
      if (shift_i) hi_q <= {hi_q[HI_W-9:0], data_i};
      if (split_i) begin
        b0_q <= data_i[7];   // reserved bits 6..1 dropped
        e8_q <= data_i[0];
      end
      if (done_i) begin
        base_q <= {hi_q, b0_q};
        ext_q  <= {e8_q, data_i};
      end
    end
  end

  assign base_o = base_q;
  assign ext_o  = ext_q;
  assign vld_o  = vld_q;

  AST_CAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R8
  AST_CAP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> vld_o); // R8
endmodule

// File: rtl/ts_pcr_scale.sv
module ts_pcr_scale
  import ts_pcr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vld_i,
  input  base_t base_i,
  input  ext_t  ext_i,
  output logic  vld_o,
  output pcr_t  pcr_o,
  output base_t base_o,
  output ext_t  ext_o
);
  // 300 = 256 + 32 + 8 + 4
  function automatic pcr_t fold(base_t b, ext_t e);
    pcr_t w;
    w = PCR_W'(b);
    return (w << 8) + (w << 5) + (w << 3) + (w << 2) + PCR_W'(e);
  endfunction

  pcr_t  pcr_q;
  base_t base_q;
  ext_t  ext_q;
  logic  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcr_q  <= '0;
      base_q <= '0;
      ext_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        pcr_q  <= fold(base_i, ext_i);
        base_q <= base_i;
        ext_q  <= ext_i;
      end
    end
  end

  assign vld_o  = vld_q;
  assign pcr_o  = pcr_q;
  assign base_o = base_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/ts_pcr_extractor.sv
module ts_pcr_extractor
  import ts_pcr_pkg::*;
#(
  parameter int         PKT_LEN    = 188,
  parameter logic [7:0] SYNC_BYTE  = 8'h47,
  parameter int         MIN_AF_LEN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              sop_i,
  input  logic [7:0]        byte_i,
  output logic              pcr_valid_o,
  output logic [PCR_W-1:0]  pcr_o,
  output logic [BASE_W-1:0] pcr_base_o,
  output logic [EXT_W-1:0]  pcr_ext_o
);
  logic  shift, split, done, cap_vld;
  base_t cap_base;
  ext_t  cap_ext;

  ts_pkt_parser #(
    .PKT_LEN(PKT_LEN), .SYNC_BYTE(SYNC_BYTE), .AF_BIT(5), .FLAG_BIT(4),
    .MIN_AF_LEN(MIN_AF_LEN)
  ) u_parser (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(byte_valid_i), .sop_i(sop_i),
    .data_i(byte_i), .shift_o(shift), .split_o(split), .done_o(done)
  );

  ts_pcr_capture u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(byte_i), .shift_i(shift),
    .split_i(split), .done_i(done), .base_o(cap_base), .ext_o(cap_ext),
    .vld_o(cap_vld)
  );

  ts_pcr_scale u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(cap_vld), .base_i(cap_base),
    .ext_i(cap_ext), .vld_o(pcr_valid_o), .pcr_o(pcr_o),
    .base_o(pcr_base_o), .ext_o(pcr_ext_o)
  );

  AST_SUM_300: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcr_valid_o |-> pcr_o == (42'(pcr_base_o) * 42'd300 + 42'(pcr_ext_o))); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcr_valid_o |=> !pcr_valid_o); // R8
  AST_HOLD_PCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcr_valid_o |-> $stable(pcr_o) && $stable(pcr_base_o) && $stable(pcr_ext_o)); // R11
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !pcr_valid_o); // R1
endmodule

// File: tb/tb_ts_pcr_extractor.sv
module tb_ts_pcr_extractor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic        sop_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        pcr_valid_o;
  logic [41:0] pcr_o;
  logic [32:0] pcr_base_o;
  logic [8:0]  pcr_ext_o;

  ts_pcr_extractor dut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .sop_i(sop_i),
    .byte_i(byte_i), .pcr_valid_o(pcr_valid_o), .pcr_o(pcr_o),
    .pcr_base_o(pcr_base_o), .pcr_ext_o(pcr_ext_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int unsigned at;
    logic [32:0] b;
    logic [8:0]  e;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int unsigned cyc = 0;
  int          total = 0;
  int          bad = 0;
  int          seen = 0;
  logic [41:0] last_pcr = '0;
  logic [7:0]  pkt [0:187];
  int unsigned seed_dummy;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [41:0] ref_pcr(logic [32:0] b, logic [8:0] e);
    longint unsigned v;
    v = longint'(b) * 300 + longint'(e);
    return v[41:0];
  endfunction

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every strobe against the expected queue
  always @(negedge clk) begin
    if (rst_ni) begin
      bit due;
      due = (q.size() > 0) && (q[0].at == cyc);
      if (pcr_valid_o) seen++;
      if (pcr_valid_o && !due) begin
        chk(0, "R8", "unexpected strobe", 1, 0);
      end else if (due && !pcr_valid_o) begin
        chk(0, {q[0].tag, "/R8"}, "missing strobe", 0, 1);
        void'(q.pop_front());
      end else if (due) begin
        chk(pcr_base_o == q[0].b, {q[0].tag, "/R6"}, "base", pcr_base_o, q[0].b);
        chk(pcr_ext_o == q[0].e, {q[0].tag, "/R6"}, "ext", pcr_ext_o, q[0].e);
        chk(pcr_o == ref_pcr(q[0].b, q[0].e), {q[0].tag, "/R7"}, "pcr",
            pcr_o, ref_pcr(q[0].b, q[0].e));
        last_pcr = ref_pcr(q[0].b, q[0].e);
        void'(q.pop_front());
      end
    end
  end

  task automatic mk_good(logic [32:0] b, logic [8:0] e);
    for (int i = 0; i < 188; i++) pkt[i] = 8'($urandom);
    pkt[0]  = 8'h47;
    pkt[3]  = pkt[3] | 8'h20;
    pkt[4]  = 8'(7 + $urandom_range(0, 176));
    pkt[5]  = pkt[5] | 8'h10;
    pkt[6]  = b[32:25];
    pkt[7]  = b[24:17];
    pkt[8]  = b[16:9];
    pkt[9]  = b[8:1];
    pkt[10] = {b[0], 6'($urandom), e[8]};
    pkt[11] = e[7:0];
  endtask

  // drive the first n bytes of pkt, idle gaps with probability gap_pct
  task automatic send(int n, int gap_pct, string tag);
    bit qual;
    qual = (n >= 12) && pkt[0] == 8'h47 && pkt[3][5] && pkt[4] >= 8'd7 && pkt[5][4];
    for (int i = 0; i < n; i++) begin
      while (int'($urandom_range(0, 99)) < gap_pct) begin
        @(negedge clk);
        byte_valid_i = 1'b0;
        sop_i = 1'b0;
        byte_i = 8'($urandom);
      end
      @(negedge clk);
      byte_valid_i = 1'b1;
      sop_i = (i == 0);
      byte_i = pkt[i];
      if (i == 11 && qual)
        q.push_back('{at: cyc + 2, b: {pkt[6], pkt[7], pkt[8], pkt[9], pkt[10][7]},
                      e: {pkt[10][0], pkt[11]}, tag: tag});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid_i = 1'b0;
      sop_i = 1'b0;
    end
  endtask

  task automatic drop_case(string req);
    int s0;
    s0 = seen;
    send(188, 10, req);
    idle(4);
    chk(seen == s0, req, "dropped packet strobes", seen - s0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_0123);
    repeat (3) @(negedge clk);
    chk(pcr_valid_o == 1'b0, "R1", "valid in reset", pcr_valid_o, 0);
    chk(pcr_o == '0, "R1", "pcr in reset", pcr_o, 0);
    rst_ni = 1'b1;
    idle(2);
    chk(pcr_base_o == '0, "R1", "base after reset", pcr_base_o, 0);
    chk(pcr_ext_o == '0, "R1", "ext after reset", pcr_ext_o, 0);

    // R7 extremes, R6 reserved bits all set
    mk_good('1, 9'h1ff); pkt[10][6:1] = 6'h3f; send(188, 0, "R7max");
    mk_good(33'h1_2345_6789, 9'h0a5); pkt[10][6:1] = 6'h00; send(188, 0, "R6");
    mk_good('0, 9'h12b); send(188, 0, "R7");
    idle(4);

    // drop conditions
    mk_good(33'h55, 9'h3); pkt[0] = 8'h46; drop_case("R2");
    mk_good(33'h56, 9'h3); pkt[3] = pkt[3] & 8'hdf; drop_case("R3");
    mk_good(33'h57, 9'h3); pkt[4] = 8'd0; drop_case("R4");
    mk_good(33'h58, 9'h3); pkt[4] = 8'd6; drop_case("R4");
    mk_good(33'h59, 9'h3); pkt[5] = pkt[5] & 8'hef; drop_case("R5");

    // R9 heavy idle gaps
    mk_good(33'h0_dead_beef, 9'h111); send(188, 70, "R9");
    idle(4);

    // R10 truncated capture then restart
    begin
      int s0;
      s0 = seen;
      mk_good(33'h1_0000_0001, 9'h001); send(9, 0, "R10");
      mk_good(33'h0_abcd_0123, 9'h0fe); send(188, 0, "R10");
      idle(4);
      chk(seen - s0 == 1, "R10", "strobes after abort", seen - s0, 1);
      // R10 result leaving while next packet starts
      s0 = seen;
      mk_good(33'h0_1111_2222, 9'h033); send(12, 0, "R10");
      mk_good(33'h1_3333_4444, 9'h144); send(188, 0, "R10");
      idle(4);
      chk(seen - s0 == 2, "R10", "back-to-back strobes", seen - s0, 2);
    end

    // R11 hold between strobes
    idle(20);
    chk(pcr_o == last_pcr, "R11", "pcr held", pcr_o, last_pcr);

    // random packets with occasional corruption
    for (int k = 0; k < 40; k++) begin
      mk_good({1'($urandom), 32'($urandom)}, 9'($urandom));
      case ($urandom_range(0, 7))
        0: pkt[0] = 8'($urandom) & 8'hbf;
        1: pkt[3] = pkt[3] & 8'hdf;
        2: pkt[4] = 8'($urandom_range(0, 6));
        3: pkt[5] = pkt[5] & 8'hef;
        default: ;
      endcase
      send(188, 20, "R7rnd");
    end
    idle(6);
    chk(q.size() == 0, "R8", "outstanding expected strobes", q.size(), 0);
    chk(pcr_valid_o == 1'b0, "R8", "strobe low at idle", pcr_valid_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule